// File: doc/BRIEF.md
# Push-Pull Converter Clock Supervisor

This block produces the two alternating phase drives of a push-pull isolated supply. After reset the converter runs from an internal free-running source: the oscillator tick input toggles an internal converter clock, so that clock runs at half the tick rate. Once a microcontroller clock on `ext_clk` has shown eight consecutive well-formed periods, the block hands the converter over to that clock. A phase drive is active only while the selected source clock is low. The two phases take turns on successive periods, so each phase repeats every two source periods, and a longer source high time gives a smaller converter duty.

The block supervises the external clock in two ways. If the clock stays high too long, a watchdog trips and both drives stop until the clock has requalified. If it stays low too long, the converter falls back to the internal source. In parallel, a soft-start sequencer holds the output switches at reduced strength. It moves to run mode, with full strength, after the reflected-voltage comparator bit has been seen high at 128 consecutive sample points. A sample point is the rising edge of the source clock, when both drives are off. Over-voltage, over-temperature and a conversion-reset input each force the drives off, and the conversion reset also restarts soft start.

The source state machine has six states: `ST_OFF` (disabled), `ST_INT` (internal source), `ST_TO_EXT` and `ST_TO_INT` (one quiet cycle at each hand-over), `ST_EXT` (external source) and `ST_HOLD` (watchdog stop). Its transitions are:
- Any state goes to `ST_OFF` while a disable is present.
- `ST_OFF` goes to `ST_INT` once the disables are gone.
- `ST_INT` and `ST_HOLD` go to `ST_TO_EXT` once the external clock has qualified.
- `ST_TO_EXT` goes to `ST_EXT`.
- `ST_EXT` goes to `ST_HOLD` on a watchdog trip.
- `ST_EXT` goes to `ST_TO_INT` when the external clock is lost.
- `ST_TO_INT` goes to `ST_INT`.

Top module: `pp_clk_supervisor`

## Requirements
- R1: While `rst_n` is low, `phase_a`, `phase_b`, `full_drive` and `run_mode` are all 0.
- R2: With the internal source selected, each `osc_tick` pulse toggles the converter clock. A phase is driven while that clock is low, after a one-cycle blank, so a low time of T cycles gives a pulse of T-1 cycles. The phases take turns, starting with A after the block leaves `ST_OFF`.
- R3: An external period is valid when its high time lies in [HI_MIN_CYC, HI_MAX_CYC] and its low time lies in [LO_MIN_CYC, LO_MAX_CYC], both counted in `clk` cycles. An invalid period restarts the count. The block takes the external clock only after REQUAL_PERIODS (8) consecutive valid periods, and never after fewer.
- R4: With the external source selected, both phases are off while `ext_clk` is high. One phase is active for L-1 cycles of each L-cycle low time, and A and B take turns on successive periods.
- R5: If `ext_clk` stays high for more than WDOG_CYC cycles while it is the source, both phases go off. They stay off, even through later low times, until the clock has requalified with eight valid periods.
- R6: If `ext_clk` stays low for more than LO_MAX_CYC cycles while it is the source, the converter returns to the internal source and follows `osc_tick` again.
- R7: `phase_a` and `phase_b` are never high in the same cycle. A phase only rises after a cycle in which the other phase was low, and both phases are low for the cycle of each source hand-over.
- R8: `vdet_ok` is sampled only at rising edges of the selected source clock, when both drives are off. Run mode is entered on the 128th consecutive sample that finds it high. A level that is high only while a drive is on never counts.
- R9: A sample that finds `vdet_ok` low clears the qualification count, so the count must start again from zero.
- R10: Once `run_mode` is 1, `vdet_ok` is ignored and `run_mode` stays 1 until `conv_reset` is asserted.
- R11: `full_drive` is 1 only while `run_mode` is 1 and no disable is present. It is 0 in startup mode.
- R12: `ovlo_trip` or `otemp_trip` forces both phases low within two cycles and holds them low while asserted. Neither of them changes `run_mode`.
- R13: `conv_reset` forces both phases low, clears `run_mode`, and restarts the 128-sample qualification from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Microcontroller converter clock (asynchronous, synchronised inside) |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| vdet_ok | input | 1 | Reflected-voltage comparator result |
| ovlo_trip | input | 1 | Over-voltage lockout, active high |
| otemp_trip | input | 1 | Over-temperature shutdown, active high |
| conv_reset | input | 1 | Converter reset: drives off, soft start restarts |
| phase_a | output | 1 | First push-pull phase drive |
| phase_b | output | 1 | Second push-pull phase drive |
| full_drive | output | 1 | 1 selects full switch strength, 0 selects reduced strength |
| run_mode | output | 1 | 1 once soft start has completed |

## Verification
A wrong source state shows at the phase pins within a few cycles. In the wrong state the pulses follow `osc_tick` when they should follow `ext_clk`, or the other way round, or pulses appear in a period where `ST_HOLD` should keep the pins quiet. A corrupted phase-select bit shows up as two A pulses or two B pulses in a row, or as an overlap. A qualification counter that is off by one changes the exact period at which pulses first appear, and the exact sample at which `run_mode` rises. The bench therefore checks both of these on the boundary cycle and on the cycle just before it.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_INT    = 3'd1,
        ST_TO_EXT = 3'd2,
        ST_EXT    = 3'd3,
        ST_TO_INT = 3'd4,
        ST_HOLD   = 3'd5
    } pp_state_e;

endpackage

// File: rtl/pp_ext_monitor.sv
module pp_ext_monitor #(
    parameter int HI_MIN_CYC     = 60,
    parameter int HI_MAX_CYC     = 375,
    parameter int LO_MIN_CYC     = 250,
    parameter int LO_MAX_CYC     = 1000,
    parameter int WDOG_CYC       = 5000,
    parameter int REQUAL_PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_i,
    output logic ext_s_o,
    output logic qual_o,
    output logic wdog_o,
    output logic lost_o
);

    localparam int CNT_TOP = ((WDOG_CYC > LO_MAX_CYC) ? WDOG_CYC : LO_MAX_CYC) + 1;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam int QW      = $clog2(REQUAL_PERIODS + 1);

    localparam logic [CW-1:0] TOP_C    = CW'(CNT_TOP);
    localparam logic [CW-1:0] HI_MIN_C = CW'(HI_MIN_CYC);
    localparam logic [CW-1:0] HI_MAX_C = CW'(HI_MAX_CYC);
    localparam logic [CW-1:0] LO_MIN_C = CW'(LO_MIN_CYC);
    localparam logic [CW-1:0] LO_MAX_C = CW'(LO_MAX_CYC);
    localparam logic [CW-1:0] WDOG_C   = CW'(WDOG_CYC);
    localparam logic [QW-1:0] REQ_C    = QW'(REQUAL_PERIODS);

    logic [1:0]    sync_q;
    logic          ext_d;
    logic          ext_s;
    logic          rise;
    logic          fall;
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] lo_cnt;
    logic [CW-1:0] hi_len;
    logic          hi_seen;
    logic          have_rise;
    logic          period_ok;
    logic [QW-1:0] qcnt;

    assign ext_s = sync_q[1];
    assign rise  = ext_s & ~ext_d;
    assign fall  = ~ext_s & ext_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            ext_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_clk_i};
            ext_d  <= ext_s;
        end
    end

    // Length counters for the current high and low stretches, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            if (rise)
                hi_cnt <= CW'(1);
            else if (ext_s && hi_cnt != TOP_C)
                hi_cnt <= hi_cnt + CW'(1);
            if (fall)
                lo_cnt <= CW'(1);
            else if (!ext_s && lo_cnt != TOP_C)
                lo_cnt <= lo_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len    <= '0;
            hi_seen   <= 1'b0;
            have_rise <= 1'b0;
        end else begin
            if (rise)
                have_rise <= 1'b1;
            if (fall) begin
                hi_len  <= hi_cnt;
                hi_seen <= have_rise;
            end
        end
    end

    assign period_ok = hi_seen
                     && (hi_len >= HI_MIN_C) && (hi_len <= HI_MAX_C)
                     && (lo_cnt >= LO_MIN_C) && (lo_cnt <= LO_MAX_C);

    assign wdog_o = ext_s && (hi_cnt > WDOG_C);
    assign lost_o = !ext_s && (lo_cnt > LO_MAX_C);

    // Count of consecutive valid periods, judged at each rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            qcnt <= '0;
        else if (wdog_o || lost_o)
            qcnt <= '0;
        else if (rise) begin
            if (!period_ok)
                qcnt <= '0;
            else if (qcnt != REQ_C)
                qcnt <= qcnt + QW'(1);
        end
    end

    assign qual_o  = (qcnt == REQ_C);
    assign ext_s_o = ext_s;

    AST_QUAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt <= REQ_C); // R3
    AST_WDOG_DROPS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_o |=> !qual_o); // R5
    AST_LOST_DROPS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> !qual_o); // R6

endmodule

// File: rtl/pp_src_fsm.sv
module pp_src_fsm
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disable_i,
    input  logic int_ck_i,
    input  logic ext_s_i,
    input  logic qual_i,
    input  logic wdog_i,
    input  logic lost_i,
    output logic phase_a_o,
    output logic phase_b_o,
    output logic sample_o,
    output logic drive_en_o
);

    pp_state_e st_q;
    pp_state_e st_nxt;
    logic      src_hi;
    logic      src_prev;
    logic      sel_b;
    logic      active;
    logic      drive_on;
    logic      ph_a_q;
    logic      ph_b_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_OFF;
        else
            st_q <= st_nxt;
    end

    // Transitions
    always_comb begin
        st_nxt = st_q;
        if (disable_i) begin
            st_nxt = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:    st_nxt = ST_INT;
                ST_INT:    if (qual_i) st_nxt = ST_TO_EXT;
                ST_TO_EXT: st_nxt = ST_EXT;
                ST_EXT: begin
                    if (wdog_i)      st_nxt = ST_HOLD;
                    else if (lost_i) st_nxt = ST_TO_INT;
                end
                ST_TO_INT: st_nxt = ST_INT;
                ST_HOLD:   if (qual_i) st_nxt = ST_TO_EXT;
                default:   st_nxt = ST_OFF;
            endcase
        end
    end

    // Source clock seen by the phase logic; any non-driving state looks high (off).
    always_comb begin
        unique case (st_q)
            ST_INT:  src_hi = int_ck_i;
            ST_EXT:  src_hi = ext_s_i;
            default: src_hi = 1'b1;
        endcase
    end

    assign active   = (st_q == ST_INT) || (st_q == ST_EXT);
    assign drive_on = active && !src_hi && !src_prev;
    assign sample_o = active && src_hi && !src_prev;

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= 1'b1;
            sel_b    <= 1'b0;
            ph_a_q   <= 1'b0;
            ph_b_q   <= 1'b0;
        end else begin
            src_prev <= src_hi;
            if (st_q == ST_OFF)
                sel_b <= 1'b0;
            else if (sample_o)
                sel_b <= ~sel_b;
            ph_a_q <= drive_on && !sel_b && !ph_b_q;
            ph_b_q <= drive_on &&  sel_b && !ph_a_q;
        end
    end

    assign phase_a_o  = ph_a_q;
    assign phase_b_o  = ph_b_q;
    assign drive_en_o = (st_q != ST_OFF);

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_a_q && ph_b_q)); // R7
    AST_A_AFTER_B_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_a_q) |-> !$past(ph_b_q)); // R7
    AST_B_AFTER_A_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_b_q) |-> !$past(ph_a_q)); // R7
    AST_SWAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TO_EXT || st_q == ST_TO_INT) |=> (!ph_a_q && !ph_b_q)); // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> (!ph_a_q && !ph_b_q)); // R5
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (st_q == ST_OFF)); // R12

endmodule

// File: rtl/pp_softstart.sv
module pp_softstart #(
    parameter int SOFTSTART_SAMPLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic sample_i,
    input  logic vdet_i,
    output logic run_o
);

    localparam int SW = $clog2(SOFTSTART_SAMPLES + 1);
    localparam logic [SW-1:0] LAST_C = SW'(SOFTSTART_SAMPLES - 1);

    logic [SW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (sample_i && !run_q) begin
            if (!vdet_i)
                cnt_q <= '0;
            else begin
                cnt_q <= cnt_q + SW'(1);
                if (cnt_q == LAST_C)
                    run_q <= 1'b1;
            end
        end
    end

    assign run_o = run_q;

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !clr_i) |=> run_q); // R10
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(sample_i && vdet_i)); // R8
    AST_CLR_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !run_q); // R13

endmodule

// File: rtl/pp_clk_supervisor.sv
module pp_clk_supervisor #(
    parameter int HI_MIN_CYC        = 60,
    parameter int HI_MAX_CYC        = 375,
    parameter int LO_MIN_CYC        = 250,
    parameter int LO_MAX_CYC        = 1000,
    parameter int WDOG_CYC          = 5000,
    parameter int REQUAL_PERIODS    = 8,
    parameter int SOFTSTART_SAMPLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic osc_tick,
    input  logic vdet_ok,
    input  logic ovlo_trip,
    input  logic otemp_trip,
    input  logic conv_reset,
    output logic phase_a,
    output logic phase_b,
    output logic full_drive,
    output logic run_mode
);

    logic int_ck_q;
    logic ext_s;
    logic qual;
    logic wdog;
    logic lost;
    logic sample;
    logic drive_en;
    logic run;
    logic dis;

    assign dis = ovlo_trip | otemp_trip | conv_reset;

    // Internal converter clock: half the oscillator tick rate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            int_ck_q <= 1'b0;
        else if (osc_tick)
            int_ck_q <= ~int_ck_q;
    end

    pp_ext_monitor #(
        .HI_MIN_CYC    (HI_MIN_CYC),
        .HI_MAX_CYC    (HI_MAX_CYC),
        .LO_MIN_CYC    (LO_MIN_CYC),
        .LO_MAX_CYC    (LO_MAX_CYC),
        .WDOG_CYC      (WDOG_CYC),
        .REQUAL_PERIODS(REQUAL_PERIODS)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk_i(ext_clk),
        .ext_s_o  (ext_s),
        .qual_o   (qual),
        .wdog_o   (wdog),
        .lost_o   (lost)
    );

    pp_src_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .disable_i (dis),
        .int_ck_i  (int_ck_q),
        .ext_s_i   (ext_s),
        .qual_i    (qual),
        .wdog_i    (wdog),
        .lost_i    (lost),
        .phase_a_o (phase_a),
        .phase_b_o (phase_b),
        .sample_o  (sample),
        .drive_en_o(drive_en)
    );

    pp_softstart #(
        .SOFTSTART_SAMPLES(SOFTSTART_SAMPLES)
    ) u_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (conv_reset),
        .sample_i(sample),
        .vdet_i  (vdet_ok),
        .run_o   (run)
    );

    assign run_mode   = run;
    assign full_drive = run & drive_en;

    AST_FULL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        full_drive |-> run_mode); // R11
    AST_TRIP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovlo_trip || otemp_trip) |=> !full_drive); // R12

endmodule

// File: tb/sim_pp_clk_supervisor.sv
module sim_pp_clk_supervisor;

    localparam int T_TICK = 10;
    localparam int EH     = 8;
    localparam int EL     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_clk = 1'b0;
    logic osc_tick = 1'b0;
    logic vdet_ok = 1'b0;
    logic ovlo_trip = 1'b0;
    logic otemp_trip = 1'b0;
    logic conv_reset = 1'b0;
    logic phase_a;
    logic phase_b;
    logic full_drive;
    logic run_mode;

    int vectors = 0;
    int miscompares = 0;
    int rises_a = 0, rises_b = 0, width_a = 0, width_b = 0;
    int wa = 0, wb = 0, both_high = 0;
    logic pa_d = 1'b0, pb_d = 1'b0;
    logic ic = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    pp_clk_supervisor #(
        .HI_MIN_CYC(4), .HI_MAX_CYC(20), .LO_MIN_CYC(4),
        .LO_MAX_CYC(40), .WDOG_CYC(50)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .osc_tick(osc_tick),
        .vdet_ok(vdet_ok), .ovlo_trip(ovlo_trip), .otemp_trip(otemp_trip),
        .conv_reset(conv_reset), .phase_a(phase_a), .phase_b(phase_b),
        .full_drive(full_drive), .run_mode(run_mode)
    );

    always @(negedge clk) begin
        if (phase_a && !pa_d) rises_a++;
        if (phase_b && !pb_d) rises_b++;
        if (phase_a) wa++; else if (wa != 0) begin width_a = wa; wa = 0; end
        if (phase_b) wb++; else if (wb != 0) begin width_b = wb; wb = 0; end
        if (phase_a && phase_b) both_high++;
        pa_d = phase_a;
        pb_d = phase_b;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic dv);
        @(negedge clk);
        osc_tick = 1'b1;
        vdet_ok  = dv;
        ic       = ~ic;
        @(negedge clk);
        osc_tick = 1'b0;
        repeat (T_TICK - 2) @(negedge clk);
    endtask

    task automatic pairs(input int n, input logic dv);
        for (int i = 0; i < n; i++) begin
            tick(dv);
            tick(dv);
        end
    endtask

    task automatic ext_cycle(input int h, input int l);
        @(negedge clk);
        ext_clk = 1'b1;
        repeat (h - 1) @(negedge clk);
        @(negedge clk);
        ext_clk = 1'b0;
        repeat (l - 1) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 phase_a in reset", int'(phase_a), 0);
        chk("R1 phase_b in reset", int'(phase_b), 0);
        chk("R1 run_mode in reset", int'(run_mode), 0);
        chk("R1 full_drive in reset", int'(full_drive), 0);
    endtask

    task automatic t_internal();
        int ra0, rb0;
        ra0 = rises_a; rb0 = rises_b;
        pairs(4, 1'b0);
        chk("R2 internal pulse width A", width_a, T_TICK - 1);
        chk("R2 internal pulse width B", width_b, T_TICK - 1);
        chk("R2 phases alternate", int'((rises_a - ra0) == (rises_b - rb0)), 1);
        chk("R11 startup strength", int'(full_drive), 0);
    endtask

    task automatic t_softstart();
        pairs(100, 1'b1);
        pairs(1, 1'b0);
        pairs(127, 1'b1);
        chk("R9 count cleared by low sample", int'(run_mode), 0);
        pairs(1, 1'b1);
        chk("R8 run after 128 samples", int'(run_mode), 1);
        chk("R11 full strength in run", int'(full_drive), 1);
    endtask

    task automatic t_run_sticky();
        pairs(5, 1'b0);
        chk("R10 detect ignored in run", int'(run_mode), 1);
    endtask

    task automatic t_disable();
        int r0;
        @(negedge clk); ovlo_trip = 1'b1;
        repeat (3) @(negedge clk);
        r0 = rises_a + rises_b;
        chk("R12 ovlo phase_a off", int'(phase_a), 0);
        chk("R11 ovlo full_drive off", int'(full_drive), 0);
        pairs(2, 1'b0);
        chk("R12 ovlo no pulses", rises_a + rises_b - r0, 0);
        chk("R12 ovlo keeps run", int'(run_mode), 1);
        ovlo_trip = 1'b0; otemp_trip = 1'b1;
        repeat (3) @(negedge clk);
        r0 = rises_a + rises_b;
        pairs(2, 1'b0);
        chk("R12 otemp no pulses", rises_a + rises_b - r0, 0);
        chk("R12 otemp phase_b off", int'(phase_b), 0);
        otemp_trip = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 full strength back", int'(full_drive), 1);
    endtask

    task automatic t_conv_reset();
        @(negedge clk); conv_reset = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13 run cleared", int'(run_mode), 0);
        chk("R13 drives off", int'(phase_a | phase_b), 0);
        conv_reset = 1'b0;
        pairs(3, 1'b1);
        chk("R13 sequence restarted", int'(run_mode), 0);
    endtask

    task automatic t_off_sample();
        for (int i = 0; i < 280; i++) tick(ic);
        chk("R8 detect while driving ignored", int'(run_mode), 0);
    endtask

    task automatic t_ext_qual();
        int r0;
        repeat (10) @(negedge clk);
        r0 = rises_a + rises_b;
        for (int i = 0; i < 5; i++) ext_cycle(EH, EL);
        ext_cycle(30, EL);
        for (int i = 0; i < 8; i++) ext_cycle(EH, EL);
        chk("R3 no takeover before 8 valid", rises_a + rises_b - r0, 0);
        ext_cycle(EH, EL);
        chk("R3 takeover on 8th valid", int'(rises_a + rises_b - r0 > 0), 1);
    endtask

    task automatic t_ext_run();
        int ra0, rb0;
        ra0 = rises_a; rb0 = rises_b;
        for (int i = 0; i < 4; i++) ext_cycle(EH, EL);
        chk("R4 A pulses", rises_a - ra0, 2);
        chk("R4 B pulses", rises_b - rb0, 2);
        chk("R4 width A", width_a, EL - 1);
        chk("R4 width B", width_b, EL - 1);
    endtask

    task automatic t_watchdog();
        int r0;
        @(negedge clk); ext_clk = 1'b1;
        repeat (70) @(negedge clk);
        chk("R5 watchdog drives off", int'(phase_a | phase_b), 0);
        r0 = rises_a + rises_b;
        ext_clk = 1'b0;
        repeat (15) @(negedge clk);
        chk("R5 held through low time", rises_a + rises_b - r0, 0);
        for (int i = 0; i < 8; i++) ext_cycle(EH, EL);
        chk("R5 no restart before requal", rises_a + rises_b - r0, 0);
        ext_cycle(EH, EL);
        chk("R5 restart after requal", int'(rises_a + rises_b - r0 > 0), 1);
    endtask

    task automatic t_loss();
        int r0;
        @(negedge clk); ext_clk = 1'b0;
        repeat (60) @(negedge clk);
        r0 = rises_a + rises_b;
        pairs(4, 1'b0);
        chk("R6 internal pulses resume", int'(rises_a + rises_b - r0 >= 3), 1);
        chk("R6 tick-timed width A", width_a, T_TICK - 1);
        chk("R6 tick-timed width B", width_b, T_TICK - 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_internal();
        t_softstart();
        t_run_sticky();
        t_disable();
        t_conv_reset();
        t_off_sample();
        t_ext_qual();
        t_ext_run();
        t_watchdog();
        t_loss();
        chk("R7 phases never overlap", both_high, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule